// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of address translations. Each entry maps a virtual page number to a physical frame number. Each entry also carries an address-space identifier, so translations that belong to several processes can be resident together. A lookup compares the requested page number and identifier against every entry in parallel. It returns a hit flag and the matching frame in the same cycle.

On a miss, the surrounding logic fetches the translation from the in-memory page table and installs it through the fill port. A purge input can invalidate every entry at once. A second purge input invalidates only the entries of one address space, so a context switch does not have to discard the translations of other processes.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid. Any lookup then returns `lk_hit`=0 and `lk_pfn`=0.
- R2: A lookup hits only when a valid entry matches both `lk_vpn` and `lk_asid`. The stored frame appears on `lk_pfn` combinationally, in the same cycle.
- R3: On a miss, `lk_hit` is 0 and `lk_pfn` is 0.
- R4: A fill that matches no resident entry writes the lowest-index entry that is invalid. The new translation is visible to lookups from the cycle after the fill edge.
- R5: When all entries are valid, a fill overwrites the entry named by a round-robin pointer. The pointer is 0 after reset and advances by one (modulo the entry count) after each such replacement.
- R6: A fill whose page number and identifier already match a valid entry updates the frame of that entry in place. No second copy is created, so at most one entry ever matches a lookup.
- R7: `flush_all` invalidates every entry at the next clock edge.
- R8: `flush_one` invalidates only the entries whose identifier equals `flush_id`. Entries of other identifiers keep hitting.
- R9: When a fill and a flush occur in the same cycle, the flush is applied first and the fill second. The filled translation is resident afterwards, even if the flush covers its identifier.
- R10: The same page number under two different identifiers occupies two entries. Each entry returns its own frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_pfn | output | 20 | Matched frame number, 0 on a miss |
| fill_en | input | 1 | Install a translation at this edge |
| fill_vpn | input | 20 | Page number to install |
| fill_asid | input | 8 | Identifier to install |
| fill_pfn | input | 20 | Frame number to install |
| flush_all | input | 1 | Invalidate every entry |
| flush_one | input | 1 | Invalidate the entries of one identifier |
| flush_id | input | 8 | Identifier purged by `flush_one` |

## Verification
The bench targets victim choice. It fills a hole left by a selective flush and then replays replacements until the pointer reaches that slot. A design that picked the wrong free slot would lose the translation too early, and a design whose pointer did not wrap would evict the wrong entry.

The bench re-fills an existing page and identifier with a new frame. A design that duplicated the entry would return the OR of two frames.

The bench issues a fill in the same cycle as each kind of flush. A design that applied them in the wrong order would lose the new entry.

The bench also checks that identical page numbers under two identifiers stay distinct. A design that skipped the identifier compare would return the wrong frame or lose the second entry on a selective flush.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              flush_all,
  input  logic              flush_one,
  input  logic [ASID_W-1:0] flush_id
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid, keep, fmatch, hitv;
  logic [VPN_W-1:0]   vpn  [ENTRIES];
  logic [ASID_W-1:0]  asid [ENTRIES];
  logic [PFN_W-1:0]   pfn  [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr, free_idx, tgt;
  logic               any_free;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hitv[g]   = valid[g] && vpn[g] == lk_vpn && asid[g] == lk_asid;
      assign keep[g]   = valid[g] && !flush_all && !(flush_one && asid[g] == flush_id);
      assign fmatch[g] = keep[g] && vpn[g] == fill_vpn && asid[g] == fill_asid;
    end
  endgenerate

  assign lk_hit = |hitv;

  always_comb begin
    lk_pfn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hitv[i]) lk_pfn = lk_pfn | pfn[i];
  end

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!keep[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
  end

  always_comb begin
    tgt = any_free ? free_idx : rr_ptr;
    for (int i = 0; i < ENTRIES; i++)
      if (fmatch[i]) tgt = IDX_W'(i);
  end

  wire replace = fill_en && !(|fmatch) && !any_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= '0;
      rr_ptr <= '0;
    end else begin
      valid <= keep;
      if (fill_en) valid[tgt] <= 1'b1;
      if (replace)
        rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      vpn[tgt]  <= fill_vpn;
      asid[tgt] <= fill_asid;
      pfn[tgt]  <= fill_pfn;
    end
  end

  a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitv));
  a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_pfn == '0);
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all && !fill_en |=> valid == '0);
  a_r9_fill_survives: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> $countones(valid) >= 1);
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    !replace |=> $stable(rr_ptr));
  a_r8_keeps_other: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_all && !flush_one && !fill_en |=> $stable(valid));
endmodule

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
  logic clk = 0, rst_n = 0;
  logic [19:0] lk_vpn = 0, fill_vpn = 0, fill_pfn = 0;
  logic [7:0]  lk_asid = 0, fill_asid = 0, flush_id = 0;
  logic        fill_en = 0, flush_all = 0, flush_one = 0;
  logic        lk_hit;
  logic [19:0] lk_pfn;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  asid_tlb dut (.clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_asid(fill_asid), .fill_pfn(fill_pfn), .flush_all(flush_all),
    .flush_one(flush_one), .flush_id(flush_id));

  task automatic look(input logic [19:0] v, input logic [7:0] a,
                      input logic eh, input logic [19:0] ep, input string req);
    lk_vpn = v; lk_asid = a;
    #1;
    checks++;
    if (lk_hit !== eh || lk_pfn !== ep) begin
      errors++;
      $display("FAIL %s: vpn=%h asid=%h actual hit=%b pfn=%h expected hit=%b pfn=%h",
               req, v, a, lk_hit, lk_pfn, eh, ep);
    end
  endtask

  task automatic step(input logic fe, input logic [19:0] v, input logic [7:0] a,
                      input logic [19:0] p, input logic fa, input logic fo,
                      input logic [7:0] fid);
    @(negedge clk);
    fill_en = fe; fill_vpn = v; fill_asid = a; fill_pfn = p;
    flush_all = fa; flush_one = fo; flush_id = fid;
    @(negedge clk);
    fill_en = 0; flush_all = 0; flush_one = 0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] a, input logic [19:0] p);
    step(1, v, a, p, 0, 0, 0);
  endtask

  task automatic t_reset;
    look(20'h00000, 8'h00, 0, 20'h0, "R1");
    look(20'h12345, 8'h03, 0, 20'h0, "R1");
  endtask

  task automatic t_basic;
    fill(20'h12345, 8'h03, 20'hABCDE);
    look(20'h12345, 8'h03, 1, 20'hABCDE, "R2");
    look(20'h12345, 8'h04, 0, 20'h0, "R3");
    look(20'h12346, 8'h03, 0, 20'h0, "R3");
    fill(20'h12345, 8'h04, 20'h11111);
    look(20'h12345, 8'h04, 1, 20'h11111, "R10");
    look(20'h12345, 8'h03, 1, 20'hABCDE, "R10");
  endtask

  task automatic t_update;
    fill(20'h12345, 8'h03, 20'h22222);
    look(20'h12345, 8'h03, 1, 20'h22222, "R6");
  endtask

  task automatic t_flush_id;
    step(0, 0, 0, 0, 0, 1, 8'h03);
    look(20'h12345, 8'h03, 0, 20'h0, "R8");
    look(20'h12345, 8'h04, 1, 20'h11111, "R8");
  endtask

  task automatic t_flush_all;
    step(0, 0, 0, 0, 1, 0, 0);
    look(20'h12345, 8'h04, 0, 20'h0, "R7");
  endtask

  task automatic t_round_robin;
    for (int i = 0; i < 8; i++) fill(20'h100 + 20'(i), 8'h01, 20'h200 + 20'(i));
    for (int i = 0; i < 8; i++) look(20'h100 + 20'(i), 8'h01, 1, 20'h200 + 20'(i), "R4");
    fill(20'h500, 8'h01, 20'h600);
    look(20'h100, 8'h01, 0, 20'h0, "R5");
    look(20'h101, 8'h01, 1, 20'h201, "R5");
    look(20'h500, 8'h01, 1, 20'h600, "R5");
    fill(20'h501, 8'h01, 20'h601);
    look(20'h101, 8'h01, 0, 20'h0, "R5");
    look(20'h102, 8'h01, 1, 20'h202, "R5");
  endtask

  task automatic t_first_free;
    step(0, 0, 0, 0, 1, 0, 0);
    fill(20'h1, 8'h01, 20'hA);
    fill(20'h2, 8'h02, 20'hB);
    fill(20'h3, 8'h01, 20'hC);
    step(0, 0, 0, 0, 0, 1, 8'h02);
    fill(20'h4, 8'h01, 20'hD);
    for (int i = 0; i < 5; i++) fill(20'h10 + 20'(i), 8'h01, 20'h50 + 20'(i));
    for (int i = 0; i < 7; i++) fill(20'h30 + 20'(i), 8'h01, 20'h70 + 20'(i));
    look(20'h4, 8'h01, 1, 20'hD, "R4");
    fill(20'h40, 8'h01, 20'h80);
    look(20'h4, 8'h01, 0, 20'h0, "R4");
    look(20'h40, 8'h01, 1, 20'h80, "R5");
  endtask

  task automatic t_same_cycle;
    step(1, 20'h777, 8'h05, 20'h999, 1, 0, 0);
    look(20'h777, 8'h05, 1, 20'h999, "R9");
    look(20'h40, 8'h01, 0, 20'h0, "R9");
    step(1, 20'h778, 8'h05, 20'h998, 0, 1, 8'h05);
    look(20'h778, 8'h05, 1, 20'h998, "R9");
    look(20'h777, 8'h05, 0, 20'h0, "R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset;
    t_basic;
    t_update;
    t_flush_id;
    t_flush_all;
    t_round_robin;
    t_first_free;
    t_same_cycle;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule